// File: doc/BRIEF.md
# Object Submission Cache with Hashed Lookup and Runout Log

This block takes object submissions and queues them for a downstream consumer. Each submission is a 32-bit object name, a 3-bit channel number, a method offset and a data word. There are two queues. The first is a single-entry injection slot for side-band producers. The second is a FIFO with 32 entries by default, and a build parameter raises it to 64. A puller interface drains the queued entries one at a time. Along with each entry it gives the byte offset of the object's hash-table slot. That offset is an 8-bit hash multiplied by 16, and the hash is the XOR of the four name bytes and the channel number.

The block can refuse a submission. This happens when the queues are switched off, when the access targets a channel other than the active one, when the access is a read, or when the chosen queue is full. A refused submission is never dropped silently. The block emits it as a runout record: the submitted fields, a reason code and a read/write flag, plus a slot offset inside a circular runout area. The runout area is half the size of the configured hash table.

The block keeps put and get pointers for the runout area. It drives an interrupt while any record remains unconsumed, and it reports empty, sticky overflow and the last reason in a small status word.

Top module: `cmd_cache`

## Requirements
- R1: The puller address `pullAddr` equals `{h, 4'b0000}`. Here `h` is the XOR of `pullName[31:24]`, `pullName[23:16]`, `pullName[15:8]` and `pullName[7:0]`, XORed with the zero-extended `pullChan`.
- R2: An entry held in the injection slot is presented to the puller ahead of any FIFO entry. FIFO entries leave in the order they arrived.
- R3: A refused submission carries one of three reason codes: 2 when `cacheEn` is 0, 3 when `subChan` differs from `activeChan` or `subWrite` is 0, and 1 when the chosen queue is full. If several conditions hold, 2 outranks 3, and 3 outranks 1.
- R4: An accepted submission appears on the puller outputs in the cycle after the edge that captured it. It stays there with `pullValid` high until a cycle in which `pullReady` is high.
- R5: In the cycle after a refused submission, `roWrValid` pulses high for one cycle. The record ports carry the submitted name, channel, method, data and read/write flag, the reason code, and `roWrAddr = slot*16`.
- R6: The runout area holds `128 << htSel` records (hash table 4, 8, 16 or 32 KB for `htSel` 0 to 3). Record slots are assigned in sequence and wrap modulo that capacity.
- R7: A refusal that arrives while the runout area is full produces no record and sets the overflow bit. The overflow bit then stays set until reset.
- R8: `status[0]` is 1 when the runout area is empty, `status[1]` is the overflow bit, and `status[3:2]` is the most recent reason code. `irq` is high while the runout area is non-empty. Each cycle with `roGetInc` high frees one record.
- R9: The FIFO accepts exactly `FIFO_DEPTH` entries and the injection slot accepts one.
- R10: After reset, `pullValid`, `roWrValid` and `irq` are 0 and `status` is 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cacheEn | input | 1 | Queues enabled |
| activeChan | input | 3 | Currently active channel |
| htSel | input | 2 | Hash table size select (4 KB << htSel) |
| subValid | input | 1 | Submission strobe |
| subInject | input | 1 | 1 targets the injection slot, 0 targets the FIFO |
| subWrite | input | 1 | 1 write access, 0 read access |
| subName | input | 32 | Object name |
| subChan | input | 3 | Submission channel |
| subMethod | input | 13 | Method offset |
| subData | input | 32 | Method data |
| pullReady | input | 1 | Puller takes the presented entry |
| pullValid | output | 1 | An entry is presented |
| pullName | output | 32 | Presented object name |
| pullChan | output | 3 | Presented channel |
| pullMethod | output | 13 | Presented method offset |
| pullData | output | 32 | Presented data |
| pullAddr | output | 12 | Hash-table byte offset |
| roWrValid | output | 1 | Runout record write strobe |
| roWrAddr | output | 14 | Runout record byte offset |
| roName | output | 32 | Record name |
| roChan | output | 3 | Record channel |
| roMethod | output | 13 | Record method offset |
| roData | output | 32 | Record data |
| roReason | output | 2 | Record reason code |
| roWrite | output | 1 | Record read/write flag |
| roGetInc | input | 1 | Consumer frees one runout record |
| irq | output | 1 | Runout records pending |
| status | output | 4 | {last reason, overflow, empty} |

## Verification
Both accepted entries and runout records are due exactly one clock edge after the edge that captures the submission. Status and `irq` are due one edge after the submission or the `roGetInc` pulse. The bench drives every input just after a falling edge and waits for one rising edge. It then samples at the next falling edge, so each check lands in the first cycle in which its result is due. Puller outputs are checked before `pullReady` is raised, which also confirms that the entry was held.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int CHAN_W       = 3;
  localparam int NAME_W       = 32;
  localparam int HASH_W       = 8;
  localparam int REC_BYTES    = 16;
  localparam int HT_MIN_BYTES = 4096;
  localparam int RO_MIN_SLOTS = HT_MIN_BYTES / 2 / REC_BYTES;
  localparam int HT_SEL_MAX   = 3;
  localparam int SLOT_W       = $clog2(RO_MIN_SLOTS << HT_SEL_MAX);

  typedef enum logic [1:0] {
    RSN_NONE    = 2'd0,
    RSN_FULL    = 2'd1,
    RSN_OFF     = 2'd2,
    RSN_ILLEGAL = 2'd3
  } reason_e;

  typedef struct packed {
    logic              injPush;
    logic              injPop;
    logic              fifoPush;
    logic              fifoPop;
    logic              headInj;
    logic              roEmit;
    logic [SLOT_W-1:0] roSlot;
  } strobe_t;
endpackage

// File: rtl/cc_ctrl.sv
module cc_ctrl
  import cc_pkg::*;
#(
  parameter int FIFO_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cacheEn,
  input  logic [CHAN_W-1:0] activeChan,
  input  logic [1:0]        htSel,
  input  logic              subValid,
  input  logic              subInject,
  input  logic              subWrite,
  input  logic [CHAN_W-1:0] subChan,
  input  logic              pullReady,
  input  logic              roGetInc,
  output logic              pullValid,
  output strobe_t           stb,
  output reason_e           subReason,
  output logic              irq,
  output logic [3:0]        status
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int PTR_W = SLOT_W + 1;

  logic             injFull;
  logic [CNT_W-1:0] fifoCount;
  logic [PTR_W-1:0] roPut, roGet, roCount, roCap;
  logic             roOvf, roFull, roEmpty;
  reason_e          lastReason;
  logic             accept, reject, pop;

  assign roCount = roPut - roGet;
  assign roCap   = PTR_W'(RO_MIN_SLOTS) << htSel;
  assign roFull  = roCount >= roCap;
  assign roEmpty = roCount == '0;

  // refusal ranking: disabled, then illegal access, then no room
  always_comb begin
    if (!cacheEn)
      subReason = RSN_OFF;
    else if (subChan != activeChan || !subWrite)
      subReason = RSN_ILLEGAL;
    else if (subInject ? injFull : (fifoCount == CNT_W'(FIFO_DEPTH)))
      subReason = RSN_FULL;
    else
      subReason = RSN_NONE;
  end

  assign accept    = subValid && subReason == RSN_NONE;
  assign reject    = subValid && subReason != RSN_NONE;
  assign pullValid = injFull || fifoCount != '0;
  assign pop       = pullValid && pullReady;

  always_comb begin
    stb          = '0;
    stb.injPush  = accept && subInject;
    stb.fifoPush = accept && !subInject;
    stb.headInj  = injFull;
    stb.injPop   = pop && injFull;
    stb.fifoPop  = pop && !injFull;
    stb.roEmit   = reject && !roFull;
    stb.roSlot   = roPut[SLOT_W-1:0] & (roCap[SLOT_W-1:0] - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      injFull    <= 1'b0;
      fifoCount  <= '0;
      roPut      <= '0;
      roGet      <= '0;
      roOvf      <= 1'b0;
      lastReason <= RSN_NONE;
    end else begin
      if (stb.injPush)     injFull <= 1'b1;
      else if (stb.injPop) injFull <= 1'b0;
      fifoCount <= fifoCount + CNT_W'(stb.fifoPush) - CNT_W'(stb.fifoPop);
      if (reject) begin
        lastReason <= subReason;
        if (roFull) roOvf <= 1'b1;
        else        roPut <= roPut + 1'b1;
      end
      if (roGetInc && !roEmpty) roGet <= roGet + 1'b1;
    end
  end

  assign irq    = !roEmpty;
  assign status = {lastReason, roOvf, roEmpty};

  a_r9_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifoCount <= CNT_W'(FIFO_DEPTH));
  a_r6_runout_bound: assert property (@(posedge clk) disable iff (!rst_n)
    roCount <= roCap);
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    roOvf |=> roOvf);
  a_r4_hold_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (pullValid && !pullReady) |=> pullValid);
endmodule

// File: rtl/cc_datapath.sv
module cc_datapath
  import cc_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int METHOD_W   = 13,
  parameter int DATA_W     = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             stb,
  input  reason_e             subReason,
  input  logic                subWrite,
  input  logic [NAME_W-1:0]   subName,
  input  logic [CHAN_W-1:0]   subChan,
  input  logic [METHOD_W-1:0] subMethod,
  input  logic [DATA_W-1:0]   subData,
  output logic [NAME_W-1:0]   pullName,
  output logic [CHAN_W-1:0]   pullChan,
  output logic [METHOD_W-1:0] pullMethod,
  output logic [DATA_W-1:0]   pullData,
  output logic [HASH_W+3:0]   pullAddr,
  output logic                roWrValid,
  output logic [SLOT_W+3:0]   roWrAddr,
  output logic [NAME_W-1:0]   roName,
  output logic [CHAN_W-1:0]   roChan,
  output logic [METHOD_W-1:0] roMethod,
  output logic [DATA_W-1:0]   roData,
  output reason_e             roReason,
  output logic                roWrite
);
  localparam int ENTRY_W = NAME_W + CHAN_W + METHOD_W + DATA_W;
  localparam int AW      = $clog2(FIFO_DEPTH);
  localparam int NBYTES  = NAME_W / 8;

  logic [ENTRY_W-1:0] subEntry, injEntry, fifoHead, headEntry;
  logic [ENTRY_W-1:0] mem [FIFO_DEPTH];
  logic [AW-1:0]      wrPtr, rdPtr;

  assign subEntry = {subName, subChan, subMethod, subData};

  always_ff @(posedge clk) begin
    if (stb.injPush)  injEntry   <= subEntry;
    if (stb.fifoPush) mem[wrPtr] <= subEntry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.fifoPush) wrPtr <= wrPtr + 1'b1;
      if (stb.fifoPop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  assign fifoHead  = mem[rdPtr];
  assign headEntry = stb.headInj ? injEntry : fifoHead;
  assign {pullName, pullChan, pullMethod, pullData} = headEntry;

  // byte-folding hash chain
  logic [HASH_W-1:0] fold [NBYTES+1];
  assign fold[0] = HASH_W'(pullChan);
  for (genvar i = 0; i < NBYTES; i++) begin : g_fold
    assign fold[i+1] = fold[i] ^ pullName[8*i +: 8];
  end
  assign pullAddr = {fold[NBYTES], 4'b0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      roWrValid <= 1'b0;
      roWrAddr  <= '0;
      roName    <= '0;
      roChan    <= '0;
      roMethod  <= '0;
      roData    <= '0;
      roReason  <= RSN_NONE;
      roWrite   <= 1'b0;
    end else begin
      roWrValid <= stb.roEmit;
      if (stb.roEmit) begin
        roWrAddr <= {stb.roSlot, 4'b0000};
        roName   <= subName;
        roChan   <= subChan;
        roMethod <= subMethod;
        roData   <= subData;
        roReason <= subReason;
        roWrite  <= subWrite;
      end
    end
  end

  a_r5_record_has_reason: assert property (@(posedge clk) disable iff (!rst_n)
    roWrValid |-> roReason != RSN_NONE);
  a_r5_record_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    roWrValid |-> $past(stb.roEmit));
endmodule

// File: rtl/cmd_cache.sv
module cmd_cache
  import cc_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int METHOD_W   = 13,
  parameter int DATA_W     = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cacheEn,
  input  logic [2:0]          activeChan,
  input  logic [1:0]          htSel,
  input  logic                subValid,
  input  logic                subInject,
  input  logic                subWrite,
  input  logic [31:0]         subName,
  input  logic [2:0]          subChan,
  input  logic [METHOD_W-1:0] subMethod,
  input  logic [DATA_W-1:0]   subData,
  input  logic                pullReady,
  output logic                pullValid,
  output logic [31:0]         pullName,
  output logic [2:0]          pullChan,
  output logic [METHOD_W-1:0] pullMethod,
  output logic [DATA_W-1:0]   pullData,
  output logic [11:0]         pullAddr,
  output logic                roWrValid,
  output logic [13:0]         roWrAddr,
  output logic [31:0]         roName,
  output logic [2:0]          roChan,
  output logic [METHOD_W-1:0] roMethod,
  output logic [DATA_W-1:0]   roData,
  output logic [1:0]          roReason,
  output logic                roWrite,
  input  logic                roGetInc,
  output logic                irq,
  output logic [3:0]          status
);
  strobe_t stb;
  reason_e subReason, recReason;

  cc_ctrl #(.FIFO_DEPTH(FIFO_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cacheEn(cacheEn), .activeChan(activeChan),
    .htSel(htSel), .subValid(subValid), .subInject(subInject),
    .subWrite(subWrite), .subChan(subChan), .pullReady(pullReady),
    .roGetInc(roGetInc), .pullValid(pullValid), .stb(stb),
    .subReason(subReason), .irq(irq), .status(status)
  );

  cc_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .METHOD_W(METHOD_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .subReason(subReason),
    .subWrite(subWrite), .subName(subName), .subChan(subChan),
    .subMethod(subMethod), .subData(subData), .pullName(pullName),
    .pullChan(pullChan), .pullMethod(pullMethod), .pullData(pullData),
    .pullAddr(pullAddr), .roWrValid(roWrValid), .roWrAddr(roWrAddr),
    .roName(roName), .roChan(roChan), .roMethod(roMethod), .roData(roData),
    .roReason(recReason), .roWrite(roWrite)
  );

  assign roReason = recReason;

  a_r5_record_follows_sub: assert property (@(posedge clk) disable iff (!rst_n)
    roWrValid |-> $past(subValid));
  a_r4_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (subValid && subReason == RSN_NONE) |=> pullValid);
endmodule

// File: tb/tb_cmd_cache.sv
module tb_cmd_cache;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cacheEn = 1'b1, subValid = 1'b0, subInject = 1'b0, subWrite = 1'b1;
  logic pullReady = 1'b0, roGetInc = 1'b0;
  logic [2:0] activeChan = 3'd3, subChan = 3'd3;
  logic [1:0] htSel = 2'd0;
  logic [31:0] subName = '0, subData = '0;
  logic [12:0] subMethod = '0;
  logic pullValid, roWrValid, roWrite, irq;
  logic [31:0] pullName, pullData, roName, roData;
  logic [2:0] pullChan, roChan;
  logic [12:0] pullMethod, roMethod;
  logic [11:0] pullAddr;
  logic [13:0] roWrAddr;
  logic [1:0] roReason;
  logic [3:0] status;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_cache dut (
    .clk(clk), .rst_n(rst_n), .cacheEn(cacheEn), .activeChan(activeChan),
    .htSel(htSel), .subValid(subValid), .subInject(subInject),
    .subWrite(subWrite), .subName(subName), .subChan(subChan),
    .subMethod(subMethod), .subData(subData), .pullReady(pullReady),
    .pullValid(pullValid), .pullName(pullName), .pullChan(pullChan),
    .pullMethod(pullMethod), .pullData(pullData), .pullAddr(pullAddr),
    .roWrValid(roWrValid), .roWrAddr(roWrAddr), .roName(roName),
    .roChan(roChan), .roMethod(roMethod), .roData(roData),
    .roReason(roReason), .roWrite(roWrite), .roGetInc(roGetInc),
    .irq(irq), .status(status)
  );

  // {name, expected hash-table offset}, channel 3
  localparam logic [43:0] VEC [5] = '{
    {32'h0000_0000, 12'h030},
    {32'h1234_5678, 12'h0B0},
    {32'hFF00_FF01, 12'h020},
    {32'hDEAD_BEEF, 12'h210},
    {32'h8000_0000, 12'h830}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic submit(logic inj, logic wr, logic [31:0] nm, logic [2:0] ch, logic [31:0] dat);
    subValid = 1'b1; subInject = inj; subWrite = wr; subName = nm;
    subChan = ch; subData = dat; subMethod = dat[12:0];
    @(posedge clk);
    @(negedge clk);
    subValid = 1'b0;
  endtask

  task automatic take();
    pullReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pullReady = 1'b0;
  endtask

  task automatic pop_ro();
    roGetInc = 1'b1;
    @(posedge clk);
    @(negedge clk);
    roGetInc = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    check("R10 pullValid", pullValid, 0);
    check("R10 roWrValid", roWrValid, 0);
    check("R10 irq", irq, 0);
    check("R10 status", status, 4'b0001);

    // R1/R4 hash vectors
    for (int i = 0; i < 5; i++) begin
      submit(1'b0, 1'b1, VEC[i][43:12], 3'd3, 32'hA000 + i);
      check("R4 visible", pullValid, 1);
      check("R1 pullAddr", pullAddr, VEC[i][11:0]);
      check("R4 pullData", pullData, 32'hA000 + i);
      @(negedge clk);
      check("R4 held", pullValid, 1);
      take();
      check("R4 drained", pullValid, 0);
    end

    // R2 injection priority and FIFO order
    submit(1'b0, 1'b1, 32'h111, 3'd3, 1);
    submit(1'b0, 1'b1, 32'h222, 3'd3, 2);
    submit(1'b1, 1'b1, 32'h333, 3'd3, 3);
    check("R2 inject first", pullName, 32'h333);
    take();
    check("R2 fifo order a", pullName, 32'h111);
    take();
    check("R2 fifo order b", pullName, 32'h222);
    take();

    // R3/R5 refusals
    cacheEn = 1'b0;
    submit(1'b0, 1'b1, 32'hCAFE, 3'd5, 32'h77);
    check("R3 off outranks", roReason, 2);
    check("R5 record strobe", roWrValid, 1);
    check("R5 record addr slot0", roWrAddr, 14'h000);
    check("R5 record name", roName, 32'hCAFE);
    check("R5 record chan", roChan, 3'd5);
    check("R4 refused not queued", pullValid, 0);
    @(negedge clk);
    check("R5 one pulse", roWrValid, 0);
    check("R8 irq pending", irq, 1);
    check("R8 last reason off", status[3:2], 2);
    cacheEn = 1'b1;
    submit(1'b0, 1'b0, 32'hBEEF, 3'd3, 32'h55);
    check("R3 read illegal", roReason, 3);
    check("R5 rw flag read", roWrite, 0);
    check("R5 record addr slot1", roWrAddr, 14'h010);
    submit(1'b0, 1'b1, 32'hBEEF, 3'd1, 32'h56);
    check("R3 wrong channel", roReason, 3);
    check("R5 rw flag write", roWrite, 1);
    repeat (3) pop_ro();
    check("R8 empty after frees", status[0], 1);
    check("R8 irq clear", irq, 0);

    // R9 fill queues
    for (int i = 0; i < DEPTH; i++) submit(1'b0, 1'b1, 32'h5000 + i, 3'd3, i);
    check("R9 fifo takes depth", status[0], 1);
    submit(1'b0, 1'b1, 32'h6000, 3'd3, 0);
    check("R9 fifo full reason", roReason, 1);
    check("R9 fifo full strobe", roWrValid, 1);
    submit(1'b0, 1'b1, 32'h6001, 3'd2, 0);
    check("R3 illegal outranks full", roReason, 3);
    submit(1'b1, 1'b1, 32'h7000, 3'd3, 0);
    check("R9 inject accepted", roWrValid, 0);
    submit(1'b1, 1'b1, 32'h7001, 3'd3, 0);
    check("R9 inject full", roReason, 1);
    check("R2 inject before full fifo", pullName, 32'h7000);
    take();
    for (int i = 0; i < DEPTH; i++) begin
      check("R2 fifo sequence", pullName, 32'h5000 + i);
      take();
    end
    check("R9 all drained", pullValid, 0);

    // R6/R7 overflow at 4 KB table
    do_reset();
    for (int i = 0; i < 128; i++) submit(1'b0, 1'b1, i, 3'd0, i);
    check("R6 last slot addr", roWrAddr, 14'h7F0);
    submit(1'b0, 1'b1, 32'hF00, 3'd0, 0);
    check("R7 dropped", roWrValid, 0);
    check("R7 overflow bit", status[1], 1);
    pop_ro();
    submit(1'b0, 1'b1, 32'hF01, 3'd0, 0);
    check("R6 wrap to slot0", roWrAddr, 14'h000);
    check("R6 wrap strobe", roWrValid, 1);
    check("R7 overflow sticky", status[1], 1);

    // R6 capacity at 8 KB table
    rst_n = 1'b0;
    htSel = 2'd1;
    do_reset();
    for (int i = 0; i < 129; i++) submit(1'b0, 1'b1, i, 3'd0, i);
    check("R6 slot128 addr", roWrAddr, 14'h800);
    check("R6 no overflow", status[1], 0);
    for (int i = 0; i < 129; i++) pop_ro();
    check("R8 drained empty", status[0], 1);
    check("R8 drained irq", irq, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule